// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block executes one decoded vector operation on a scalar ALU by stepping through its elements one per clock cycle. A vector register is a run of consecutive architectural registers starting at a base index; the destination base, the two source bases and a length for each operand arrive with the start pulse. A source of length 1 is a scalar and is reused for every element. Register addresses wrap modulo the register count, so `NREG` must be a power of two and `MAXVL` must not exceed `NREG` or `XLEN`.

A small binding table, written through a configuration port, can attach a predicate register to any destination register. When an operation targets a bound destination, the low `MAXVL` bits of the predicate register are sampled at start. Element i is computed and written only when bit i is 1. A disabled element is left exactly as it was. A destination with no binding runs with every element enabled.

When the destination has length 1 and the first source is longer than 1, the block folds the enabled first-source elements into the scalar second source and writes the destination once at the end. Only associative codes are accepted for this. A subtract fold or an unknown operation code is refused with an error flag and no write.

Top module: `pvec_seq`

## Requirements
- R1: Element i of a vector operand with base b uses register (b + i) mod NREG, and elements are processed in ascending order, one per cycle.
- R2: A source whose length is 1 supplies the same register for every element.
- R3: A configuration write with `cfg_en`=1 binds predicate register `cfg_prd` to destination `cfg_dst`, and with `cfg_en`=0 removes the binding. An unbound destination has every element enabled.
- R4: Bit i of the predicate value sampled at start enables element i. A 0 bit suppresses the write, and the old register value remains.
- R5: `busy` is high from the cycle after an accepted start until the end of the `done` cycle. `done` is a single-cycle pulse in the cycle after the last element, that is N cycles after the start edge for N elements. No write happens while `busy` is low.
- R6: If `vl_d`=1 and `vl_a`>1, then rd = rs2 op a0 op a1 ... over the enabled elements of rs1, with `vl_a` elements stepped and a single write of rd in the last step cycle.
- R7: A fold with code SUB, or any code 5 to 7, asserts `err` together with `done` in the cycle after start, writes no register and steps no element.
- R8: `start` is ignored while `busy` is high, and the operation in flight is unaffected by changes on the operation inputs.
- R9: Operation codes are 0 add, 1 subtract (a - b), 2 and, 3 or, 4 xor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Binding table write strobe |
| cfg_dst | input | log2(NREG) | Destination register whose binding is written |
| cfg_en | input | 1 | 1 binds, 0 unbinds |
| cfg_prd | input | log2(NREG) | Predicate register to bind |
| start | input | 1 | Accept an operation (when idle) |
| op | input | 3 | Operation code |
| rd | input | log2(NREG) | Destination base register |
| rs1 | input | log2(NREG) | First source base register |
| rs2 | input | log2(NREG) | Second source base register |
| vl_d | input | log2(MAXVL+1) | Destination length (1..MAXVL) |
| vl_a | input | log2(MAXVL+1) | First source length (1..MAXVL) |
| vl_b | input | log2(MAXVL+1) | Second source length (1..MAXVL) |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Completion pulse |
| err | output | 1 | Operation refused (valid with done) |
| ra_a | output | log2(NREG) | First source read address |
| ra_b | output | log2(NREG) | Second source read address |
| ra_p | output | log2(NREG) | Predicate read address (sampled at start) |
| rd_a | input | XLEN | First source read data |
| rd_b | input | XLEN | Second source read data |
| rd_p | input | XLEN | Predicate read data |
| we | output | 1 | Register write enable |
| wa | output | log2(NREG) | Register write address |
| wd | output | XLEN | Register write data |

## Verification
On every cycle the assertions check the handshake: writes occur only while busy, done is a single pulse that ends busy, busy rises only after a start, a refused operation ends without stepping an element, and a start while busy does not end the operation. The register contents cannot be seen from the protocol alone. Masked elements keeping their values, scalar reuse, the address wraparound, the fold results, the effect of binding and unbinding, and the exact latency are shown only by the bench. It compares the whole register file and the cycle count after each operation against a sequential model.

// File: rtl/pvec_seq.sv
module pvec_seq #(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int MAXVL = 8,
  localparam int RW = $clog2(NREG),
  localparam int LW = $clog2(MAXVL + 1),
  localparam int IW = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [RW-1:0]   cfg_dst,
  input  logic            cfg_en,
  input  logic [RW-1:0]   cfg_prd,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [RW-1:0]   rd,
  input  logic [RW-1:0]   rs1,
  input  logic [RW-1:0]   rs2,
  input  logic [LW-1:0]   vl_d,
  input  logic [LW-1:0]   vl_a,
  input  logic [LW-1:0]   vl_b,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [RW-1:0]   ra_a,
  output logic [RW-1:0]   ra_b,
  output logic [RW-1:0]   ra_p,
  input  logic [XLEN-1:0] rd_a,
  input  logic [XLEN-1:0] rd_b,
  input  logic [XLEN-1:0] rd_p,
  output logic            we,
  output logic [RW-1:0]   wa,
  output logic [XLEN-1:0] wd
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;

  st_t              st;
  logic [2:0]       op_q;
  logic [RW-1:0]    rd_q, rs1_q, rs2_q;
  logic             vec_a, vec_b, red_q, err_q;
  logic [IW-1:0]    idx, last_q;
  logic [MAXVL-1:0] msk;
  logic [XLEN-1:0]  acc;
  logic [NREG-1:0]  bnd_en;
  logic [RW-1:0]    bnd_reg [NREG];

  function automatic logic [XLEN-1:0] alu(input logic [2:0] c,
                                          input logic [XLEN-1:0] a,
                                          input logic [XLEN-1:0] b);
    case (c)
      3'd0:    return a + b;
      3'd1:    return a - b;
      3'd2:    return a & b;
      3'd3:    return a | b;
      3'd4:    return a ^ b;
      default: return '0;
    endcase
  endfunction

  wire            red_in = (vl_d == LW'(1)) && (vl_a > LW'(1));
  wire            bad_in = (op > 3'd4) || (red_in && op == 3'd1);
  wire [LW-1:0]   len_in = red_in ? vl_a : vl_d;
  wire            run    = (st == S_RUN);
  wire            at_end = (idx == last_q);

  wire [XLEN-1:0] base    = (idx == '0) ? rd_b : acc;
  wire [XLEN-1:0] red_val = msk[idx] ? alu(op_q, base, rd_a) : base;

  assign ra_a = vec_a ? rs1_q + RW'(idx) : rs1_q;
  assign ra_b = vec_b ? rs2_q + RW'(idx) : rs2_q;
  assign ra_p = bnd_reg[rd];

  assign we = run && (red_q ? at_end : msk[idx]);
  assign wa = red_q ? rd_q : rd_q + RW'(idx);
  assign wd = red_q ? red_val : alu(op_q, rd_a, rd_b);

  assign busy = (st != S_IDLE);
  assign done = (st == S_DONE);
  assign err  = done && err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bnd_en <= '0;
      for (int i = 0; i < NREG; i++) bnd_reg[i] <= '0;
    end else if (cfg_we) begin
      bnd_en[cfg_dst]  <= cfg_en;
      bnd_reg[cfg_dst] <= cfg_prd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= '0;
      rd_q   <= '0;
      rs1_q  <= '0;
      rs2_q  <= '0;
      vec_a  <= 1'b0;
      vec_b  <= 1'b0;
      red_q  <= 1'b0;
      err_q  <= 1'b0;
      idx    <= '0;
      last_q <= '0;
      msk    <= '0;
      acc    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q   <= op;
          rd_q   <= rd;
          rs1_q  <= rs1;
          rs2_q  <= rs2;
          vec_a  <= vl_a > LW'(1);
          vec_b  <= (vl_b > LW'(1)) && !red_in;
          red_q  <= red_in;
          err_q  <= bad_in;
          idx    <= '0;
          last_q <= IW'(len_in - LW'(1));
          msk    <= bnd_en[rd] ? rd_p[MAXVL-1:0] : '1;
          st     <= bad_in ? S_DONE : S_RUN;
        end
        S_RUN: begin
          acc <= red_val;
          if (at_end) st <= S_DONE;
          else        idx <= idx + IW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pvec_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic err,
  input logic we
);
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !we); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R5
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R5
  AST_REFUSED_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !we && !$past(busy)); // R7
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && start |=> busy); // R8
endmodule

bind pvec_seq pvec_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .err(err), .we(we)
);

// File: tb/sim_pvec_seq.sv
`timescale 1ns/1ps
module sim_pvec_seq;
  localparam int XLEN = 32, NREG = 32, MAXVL = 8;
  localparam int RW = $clog2(NREG), LW = $clog2(MAXVL + 1);

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_en = 0, start = 0;
  logic [RW-1:0] cfg_dst = 0, cfg_prd = 0, rd = 0, rs1 = 0, rs2 = 0;
  logic [2:0] op = 0;
  logic [LW-1:0] vl_d = 1, vl_a = 1, vl_b = 1;
  logic busy, done, err, we;
  logic [RW-1:0] ra_a, ra_b, ra_p, wa;
  logic [XLEN-1:0] rd_a, rd_b, rd_p, wd;

  logic [XLEN-1:0] rf [NREG];
  logic poke_en = 0;
  logic [RW-1:0] poke_a = 0;
  logic [XLEN-1:0] poke_d = 0;

  logic bm_en [NREG];
  logic [RW-1:0] bm_reg [NREG];
  logic [XLEN-1:0] ex [NREG];

  int errors = 0, checks = 0, cyc = 0;

  always #2 clk = ~clk;

  pvec_seq #(.XLEN(XLEN), .NREG(NREG), .MAXVL(MAXVL)) u0 (.*);

  always_comb begin
    rd_a = rf[ra_a];
    rd_b = rf[ra_b];
    rd_p = rf[ra_p];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= XLEN'(i) * 32'h9E3779B1 + 32'h1234;
    end else if (poke_en) rf[poke_a] <= poke_d;
    else if (we) rf[wa] <= wd;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles exp below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [XLEN-1:0] fn(input int c, input logic [XLEN-1:0] a,
                                         input logic [XLEN-1:0] b);
    case (c)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] got,
                     input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic poke(input int a, input logic [XLEN-1:0] d);
    @(negedge clk); poke_en = 1; poke_a = RW'(a); poke_d = d;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic bind_cfg(input int dst, input bit en, input int prd);
    @(negedge clk); cfg_we = 1; cfg_dst = RW'(dst); cfg_en = en; cfg_prd = RW'(prd);
    @(negedge clk); cfg_we = 0;
    bm_en[dst] = en; bm_reg[dst] = RW'(prd);
  endtask

  task automatic run_op(input string tag, input int c, input int d, input int s1,
                        input int s2, input int vd, input int va, input int vb,
                        input bit inject);
    bit red, bad;
    int n, lat;
    logic [MAXVL-1:0] m;
    logic [XLEN-1:0] acc;
    for (int i = 0; i < NREG; i++) ex[i] = rf[i];
    red = (vd == 1) && (va > 1);
    bad = (c > 4) || (red && c == 1);
    n = red ? va : vd;
    m = bm_en[d] ? rf[bm_reg[d]][MAXVL-1:0] : '1;
    if (!bad) begin
      if (red) begin
        acc = ex[s2];
        for (int i = 0; i < va; i++)
          if (m[i]) acc = fn(c, acc, ex[(s1 + i) % NREG]);
        ex[d] = acc;
      end else begin
        for (int i = 0; i < vd; i++)
          if (m[i]) ex[(d + i) % NREG] = fn(c, ex[(s1 + (va > 1 ? i : 0)) % NREG],
                                            ex[(s2 + (vb > 1 ? i : 0)) % NREG]);
      end
    end
    @(negedge clk);
    start = 1; op = 3'(c); rd = RW'(d); rs1 = RW'(s1); rs2 = RW'(s2);
    vl_d = LW'(vd); vl_a = LW'(va); vl_b = LW'(vb);
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, {tag, " R5 busy after start"}, XLEN'(busy), 1);
    lat = 0;
    while (done !== 1'b1 && lat < 64) begin
      if (inject && lat == 0) begin
        start = 1; op = 3'd0; rd = RW'(d + 1); rs1 = RW'(s2); vl_d = LW'(MAXVL);
      end
      @(negedge clk);
      start = 0;
      lat++;
    end
    chk(lat == (bad ? 0 : n), {tag, " R5 latency"}, XLEN'(lat), XLEN'(bad ? 0 : n));
    chk(err === bad, {tag, " R7 err flag"}, XLEN'(err), XLEN'(bad));
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, {tag, " R5 idle after done"},
        XLEN'({busy, done}), 0);
    begin
      int bad_i = -1;
      for (int i = NREG - 1; i >= 0; i--) if (rf[i] !== ex[i]) bad_i = i;
      if (bad_i < 0) chk(1, tag, 0, 0);
      else chk(0, {tag, $sformatf(" reg r%0d", bad_i)}, rf[bad_i], ex[bad_i]);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NREG; i++) begin bm_en[i] = 0; bm_reg[i] = 0; end
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && err === 0 && we === 0, "R5 reset state",
        XLEN'({busy, done, err, we}), 0);
    rst_n = 1;
    @(negedge clk);

    run_op("R1 R2 add vec+scalar", 0, 10, 0, 20, 4, 4, 1, 0);
    run_op("R1 R9 sub vec-vec", 1, 12, 2, 24, 6, 6, 6, 0);
    run_op("R1 wraparound", 4, 29, 27, 3, 5, 5, 5, 0);
    run_op("R2 scalar first source", 2, 8, 1, 16, 8, 1, 8, 0);

    poke(5, 32'hFFFF_FF56);
    bind_cfg(10, 1, 5);
    run_op("R3 R4 predicated xor", 4, 10, 0, 20, 8, 8, 1, 0);
    poke(5, 32'h0);
    run_op("R4 all masked off", 0, 10, 3, 4, 8, 8, 8, 0);
    bind_cfg(10, 0, 5);
    run_op("R3 unbound all enabled", 3, 10, 0, 20, 8, 8, 1, 0);

    run_op("R6 add fold", 0, 2, 16, 7, 1, 8, 1, 0);
    run_op("R6 xor fold", 4, 3, 16, 7, 1, 5, 1, 0);
    poke(6, 32'h0000_00A5);
    bind_cfg(2, 1, 6);
    run_op("R6 R4 masked or fold", 3, 2, 8, 9, 1, 8, 1, 0);
    bind_cfg(2, 0, 6);

    run_op("R7 sub fold refused", 1, 2, 16, 7, 1, 8, 1, 0);
    run_op("R7 code 6 refused", 6, 4, 0, 1, 4, 4, 4, 0);
    run_op("R7 code 5 refused", 5, 4, 0, 1, 1, 1, 1, 0);
    for (int c = 0; c < 5; c++)
      run_op($sformatf("R9 code %0d", c), c, 20, 12, 4, 3, 3, 3, 0);
    run_op("R8 start ignored while busy", 0, 14, 0, 22, 6, 6, 1, 1);
    run_op("R8 refused op ignores start", 7, 14, 0, 22, 6, 6, 1, 1);

    for (int k = 0; k < 250; k++) begin
      int c, d, s1, s2, vd, va, vb;
      if ($urandom_range(0, 7) == 0)
        poke($urandom_range(0, NREG - 1), $urandom());
      if ($urandom_range(0, 5) == 0)
        bind_cfg($urandom_range(0, NREG - 1), $urandom_range(0, 1) == 1,
                 $urandom_range(0, NREG - 1));
      c = $urandom_range(0, 5);
      d = $urandom_range(0, NREG - 1);
      s1 = $urandom_range(0, NREG - 1);
      s2 = $urandom_range(0, NREG - 1);
      vd = $urandom_range(1, MAXVL);
      va = ($urandom_range(0, 1) == 1) ? 1 : $urandom_range(1, MAXVL);
      vb = ($urandom_range(0, 1) == 1) ? 1 : $urandom_range(1, MAXVL);
      if ($urandom_range(0, 4) == 0) begin vd = 1; va = $urandom_range(2, MAXVL); end
      run_op($sformatf("R1 R4 R6 random %0d", k), c, d, s1, s2, vd, va, vb,
             $urandom_range(0, 9) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule